// File: doc/BRIEF.md
# Receive FCS Check and Strip Stage

This stage sits on the receive path between a 128-bit packet stream and user logic. Each beat carries sixteen bytes, and the first byte on the wire sits in the most significant byte lane. The stage runs the Ethernet CRC-32 over every frame, including its four-byte frame check sequence. At end of packet it reports a bad check on a dedicated error bit.

By default the stage removes the four FCS bytes and moves end-of-packet and the empty count so they point at the last payload byte. When the last input beat holds four or fewer bytes, that beat contains only FCS bytes. The stage then drops it and places end-of-packet on the previous beat. To make this possible, every beat is held back by one beat before it is sent on. In pass-through mode, the FCS stays in the stream and end-of-packet and empty pass through unchanged. The mode is sampled once per frame, on its start beat.

Top module: `fcs_rx_strip`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_valid` is low.
- R2: Output beats carry the input data words unchanged and in order, with byte 0 of the frame in bits 127:120. `out_sop` is high on the first output beat of each frame and only there.
- R3: In strip mode, if the final input beat holds k > 4 bytes (k = 16 − `in_empty`), end-of-packet stays on that beat and `out_empty` = `in_empty` + 4.
- R4: In strip mode, if the final input beat holds k ≤ 4 bytes, that beat is not forwarded. The previous beat carries `out_eop` with `out_empty` = 4 − k, and it leaves on the cycle after the final beat is accepted.
- R5: In pass-through mode (`keep_fcs` = 1 at start of packet), every beat is forwarded, and `out_eop` and `out_empty` equal the input values, so the FCS bytes remain.
- R6: On the end-of-packet beat, `out_err[1]` is high if the CRC register fails to reach 0xDEBB20E3 over the whole frame including its FCS, or if `in_err[1]` was high on the final input beat. The CRC uses polynomial 0x04C11DB7 processed least-significant-bit first (0xEDB88320 in that form), starts from all ones, and the FCS is the complement of the register over the payload, sent low byte first. The residue 0xDEBB20E3 is 0xC704DD7B bit-reversed.
- R7: On the end-of-packet beat, `out_err` bits 5:2 and 0 equal `in_err` of the frame's final input beat. On all other output beats, `out_err` and `out_empty` are zero, whatever `in_err` and `in_empty` held.
- R8: The mode is taken from `keep_fcs` on the start-of-packet beat. Changes to `keep_fcs` during the rest of the frame have no effect on that frame.
- R9: A final input beat that is kept appears at the output with `out_eop` two cycles after it is accepted. A non-final beat is forwarded on the cycle after the next beat of its frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| keep_fcs | input | 1 | 1 = leave FCS in stream, sampled on start beat |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 128 | Input bytes, first byte in bits 127:120 |
| in_sop | input | 1 | First beat of frame |
| in_eop | input | 1 | Final beat of frame (last FCS byte) |
| in_empty | input | 4 | Unused low-order bytes on final beat |
| in_err | input | 6 | Error flags, meaningful on final beat |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 128 | Output bytes |
| out_sop | output | 1 | First beat of frame |
| out_eop | output | 1 | Final beat of frame after adjustment |
| out_empty | output | 4 | Unused low-order bytes on final beat |
| out_err | output | 6 | Error flags; bit 1 is FCS failure |

## Verification
The busiest cycle is the one where a held end-of-packet beat from one frame must be flushed while the start beat of the next frame is accepted into the same holding slot. The second case is a short FCS-only tail that folds end-of-packet back onto the held beat while a new frame arrives on the next cycle. The bench provokes both by sending frames back to back with zero idle cycles, across all sixteen end-byte positions and in both modes. It judges each output beat against a behavioural queue built from frame length and mode, and it checks the cycle on which each end-of-packet appears.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int          FCS_BYTES        = 4;
  localparam int          ERR_W            = 6;
  localparam int          FCS_ERR_BIT      = 1;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT         = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB20E3;
endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
  import fcs_pkg::*;
#(
  parameter int BYTES = 16,
  parameter int DW    = BYTES * 8,
  parameter int EW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat_ok,
  input  logic          beat_sop,
  input  logic          beat_eop,
  input  logic [EW-1:0] beat_empty,
  input  logic [DW-1:0] beat_data,
  output logic          fcs_bad
);
  localparam int NW = EW + 1;

  // Feed the first n byte lanes, each byte least significant bit first.
  function automatic logic [31:0] crc_absorb(input logic [31:0] seed,
                                             input logic [DW-1:0] d,
                                             input logic [NW-1:0] n);
    logic [31:0] r;
    logic        fb;
    r = seed;
    for (int b = 0; b < BYTES; b++) begin
      if (b < int'(n)) begin
        for (int i = 0; i < 8; i++) begin
          fb = r[0] ^ d[DW-8-8*b+i];
          r  = {1'b0, r[31:1]} ^ ({32{fb}} & CRC_POLY_REFL);
        end
      end
    end
    return r;
  endfunction

  logic [31:0]   crc_q;
  logic [31:0]   crc_next;
  logic [NW-1:0] lanes;

  assign lanes    = beat_eop ? NW'(BYTES) - NW'(beat_empty) : NW'(BYTES);
  assign crc_next = crc_absorb(beat_sop ? CRC_INIT : crc_q, beat_data, lanes);
  assign fcs_bad  = (crc_next != CRC_GOOD_RESIDUE);

  always_ff @(posedge clk) begin
    if (rst)          crc_q <= CRC_INIT;
    else if (beat_ok) crc_q <= crc_next;
  end
endmodule

// File: rtl/fcs_tail_adj.sv
module fcs_tail_adj
  import fcs_pkg::*;
#(
  parameter int BYTES = 16,
  parameter int EW    = $clog2(BYTES)
) (
  input  logic          eop,
  input  logic          strip,
  input  logic [EW-1:0] empty,
  output logic          short_tail,
  output logic [EW-1:0] eop_empty,
  output logic [EW-1:0] prev_empty
);
  localparam int NW = EW + 1;

  function automatic logic [NW-1:0] live_bytes(input logic [EW-1:0] e);
    return NW'(BYTES) - NW'(e);
  endfunction

  logic [NW-1:0] live;
  logic [NW-1:0] fcs_left;

  assign live       = live_bytes(empty);
  assign short_tail = eop & strip & (live <= NW'(FCS_BYTES));
  assign eop_empty  = strip ? empty + EW'(FCS_BYTES) : empty;
  assign fcs_left   = NW'(FCS_BYTES) - live;
  assign prev_empty = fcs_left[EW-1:0];
endmodule

// File: rtl/fcs_rx_strip.sv
module fcs_rx_strip
  import fcs_pkg::*;
#(
  parameter int BYTES = 16,
  localparam int DW   = BYTES * 8,
  localparam int EW   = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             keep_fcs,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [EW-1:0]    in_empty,
  input  logic [ERR_W-1:0] in_err,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic [EW-1:0]    out_empty,
  output logic [ERR_W-1:0] out_err
);
  logic             keep_q;
  logic             strip_now;
  logic             fcs_bad;
  logic             tail_short;
  logic [EW-1:0]    eop_empty;
  logic [EW-1:0]    prev_empty;
  logic [ERR_W-1:0] eop_err;

  // holding slot
  logic             hold_v;
  logic [DW-1:0]    hold_data;
  logic             hold_sop;
  logic             hold_eop;
  logic [EW-1:0]    hold_empty;
  logic [ERR_W-1:0] hold_err;

  // named events
  logic drop_beat;
  logic flush_hold;
  logic fold_tail;
  logic pass_hold;
  logic load_hold;

  assign strip_now = in_sop ? ~keep_fcs : ~keep_q;

  fcs_crc_acc #(.BYTES(BYTES)) u_crc (
    .clk       (clk),
    .rst       (rst),
    .beat_ok   (in_valid),
    .beat_sop  (in_sop),
    .beat_eop  (in_eop),
    .beat_empty(in_empty),
    .beat_data (in_data),
    .fcs_bad   (fcs_bad)
  );

  fcs_tail_adj #(.BYTES(BYTES)) u_tail (
    .eop       (in_eop),
    .strip     (strip_now),
    .empty     (in_empty),
    .short_tail(tail_short),
    .eop_empty (eop_empty),
    .prev_empty(prev_empty)
  );

  always_comb begin
    eop_err              = in_err;
    eop_err[FCS_ERR_BIT] = in_err[FCS_ERR_BIT] | fcs_bad;
  end

  assign drop_beat  = in_valid & tail_short;
  assign flush_hold = hold_v & hold_eop;
  assign fold_tail  = hold_v & ~hold_eop & drop_beat;
  assign pass_hold  = hold_v & ~hold_eop & in_valid & ~drop_beat;
  assign load_hold  = in_valid & ~drop_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q     <= 1'b0;
      hold_v     <= 1'b0;
      hold_data  <= '0;
      hold_sop   <= 1'b0;
      hold_eop   <= 1'b0;
      hold_empty <= '0;
      hold_err   <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_empty  <= '0;
      out_err    <= '0;
    end else begin
      if (in_valid && in_sop) keep_q <= keep_fcs;

      out_valid <= flush_hold | fold_tail | pass_hold;
      out_data  <= hold_data;
      out_sop   <= hold_sop;
      out_eop   <= hold_eop | fold_tail;
      out_empty <= fold_tail ? prev_empty : hold_empty;
      out_err   <= fold_tail ? eop_err : hold_err;

      if (load_hold) begin
        hold_v     <= 1'b1;
        hold_data  <= in_data;
        hold_sop   <= in_sop;
        hold_eop   <= in_eop;
        hold_empty <= in_eop ? eop_empty : '0;
        hold_err   <= in_eop ? eop_err : '0;
      end else if (flush_hold || fold_tail) begin
        hold_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcs_rx_strip_chk.sv
module fcs_rx_strip_chk
  import fcs_pkg::*;
#(
  parameter int EW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_eop,
  input logic             tail_short,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_eop,
  input logic [EW-1:0]    out_empty,
  input logic [ERR_W-1:0] out_err
);
  // R1: output idle after a reset cycle
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !out_valid);

  // R2: the beat after an end-of-packet beat starts a new frame
  p_sop_after_eop_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop) |=> (!out_valid || out_sop));

  // R4: FCS-only tail moves end-of-packet to the next output cycle
  p_tail_fold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop && tail_short) |=> (out_valid && out_eop));

  // R7: non-final beats carry no error flags and no empty count
  p_quiet_mid_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |-> (out_err == '0 && out_empty == '0));

  // R9: a kept final beat leaves two cycles after acceptance
  p_eop_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eop && !tail_short) |=> ##1 (out_valid && out_eop));
endmodule

bind fcs_rx_strip fcs_rx_strip_chk #(.EW(EW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_eop    (in_eop),
  .tail_short(tail_short),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_empty (out_empty),
  .out_err   (out_err)
);

// File: tb/tb_fcs_rx_strip.sv
module tb_fcs_rx_strip;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         keep_fcs = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_sop = 1'b0;
  logic         in_eop = 1'b0;
  logic [3:0]   in_empty = '0;
  logic [5:0]   in_err = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_sop;
  logic         out_eop;
  logic [3:0]   out_empty;
  logic [5:0]   out_err;

  fcs_rx_strip dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  logic [127:0] eq_data[$];
  logic [11:0]  eq_ctl[$];   // {sop, eop, empty[3:0], err[5:0]}
  string        eq_tag[$];
  int           eq_cyc[$];
  logic [7:0]   fr[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // independent CRC: xor byte in, then shift eight times
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {24'h0, fr[k]};
      for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  // monitor: compare every output beat with the reference queue
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (eq_data.size() == 0) begin
        chk(1'b0, "R2", "unexpected beat", {127'h0, out_valid}, 128'h0);
      end else begin
        logic [127:0] ed;
        logic [11:0]  ec;
        string        tg;
        ed = eq_data.pop_front();
        ec = eq_ctl.pop_front();
        tg = eq_tag.pop_front();
        chk(out_data == ed && out_sop == ec[11], "R2", "data/sop",
            {out_sop, out_data[126:0]}, {ec[11], ed[126:0]});
        chk(out_eop == ec[10] && out_empty == ec[9:6], tg, "eop/empty",
            {123'h0, out_eop, out_empty}, {123'h0, ec[10], ec[9:6]});
        if (ec[10]) begin
          int ecy;
          chk(out_err[1] == ec[1], "R6", "fcs error bit", {127'h0, out_err[1]}, {127'h0, ec[1]});
          chk({out_err[5:2], out_err[0]} == {ec[5:2], ec[0]}, "R7", "other error bits",
              {122'h0, out_err}, {122'h0, ec[5:0]});
          ecy = eq_cyc.pop_front();
          chk(cyc == ecy, "R9", "eop cycle", 128'(cyc), 128'(ecy));
        end else begin
          chk(out_err == 6'h0 && out_empty == 4'h0, "R7", "mid-frame err/empty",
              {118'h0, out_err, out_empty}, 128'h0);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic send_frame(input int len, input bit pass, input bit bad, input int maxgap);
    logic [127:0] bd[$];
    logic [31:0]  fcs;
    logic [5:0]   rerr;
    int nb, lastk, olen, nbo;
    string kind;
    fr.delete();
    for (int k = 0; k < len - 4; k++) fr.push_back(8'($urandom));
    fcs = ~ref_crc(len - 4);
    for (int k = 0; k < 4; k++) fr.push_back(fcs[8*k +: 8]);
    if (bad) fr[len - 1 - ($urandom % 4)] ^= 8'(8'h01 << ($urandom % 8));
    nb    = (len + 15) / 16;
    lastk = len - 16 * (nb - 1);
    for (int b = 0; b < nb; b++) begin
      logic [127:0] w;
      for (int j = 0; j < 16; j++)
        w[127 - 8*j -: 8] = (16*b + j < len) ? fr[16*b + j] : 8'($urandom);
      bd.push_back(w);
    end
    rerr = 6'($urandom);
    if ($urandom % 4 != 0) rerr[1] = 1'b0;
    olen = pass ? len : len - 4;
    nbo  = (olen + 15) / 16;
    if (pass)            kind = "R5,R8";
    else if (lastk <= 4) kind = "R4,R8";
    else                 kind = "R3,R8";
    for (int b = 0; b < nbo; b++) begin
      bit last = (b == nbo - 1);
      eq_data.push_back(bd[b]);
      eq_ctl.push_back({b == 0, last, last ? 4'(16*nbo - olen) : 4'h0,
                        last ? {rerr[5:2], rerr[1] | bad, rerr[0]} : 6'h0});
      eq_tag.push_back(kind);
    end
    for (int b = 0; b < nb; b++) begin
      int gap = (maxgap > 0) ? int'($urandom % (maxgap + 1)) : 0;
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0; in_sop = 1'($urandom); in_eop = 1'($urandom);
        keep_fcs = 1'($urandom);
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = bd[b];
      in_sop   = (b == 0);
      in_eop   = (b == nb - 1);
      keep_fcs = (b == 0) ? pass : 1'($urandom);   // mid-frame toggles: R8
      in_empty = (b == nb - 1) ? 4'(16 - lastk) : 4'($urandom);
      in_err   = (b == nb - 1) ? rerr : 6'($urandom);
      if (b == nb - 1) eq_cyc.push_back(cyc + ((!pass && lastk <= 4) ? 1 : 2));
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", {127'h0, out_valid}, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", {127'h0, out_valid}, 128'h0);
    for (int p = 0; p < 2; p++)
      for (int l = 64; l < 80; l++)
        for (int e = 0; e < 2; e++) begin
          send_frame(l, 1'(p), 1'(e), (l % 3 == 0) ? 0 : 1);
          if (l % 2 == 1) @(negedge clk);
        end
    send_frame(1518, 1'b0, 1'b0, 0);
    send_frame(1517, 1'b1, 1'b1, 0);
    send_frame(1508, 1'b0, 1'b1, 1);
    send_frame(1509, 1'b0, 1'b0, 0);
    for (int k = 0; k < 12; k++)
      send_frame(64 + int'($urandom % 1455), 1'($urandom), 1'($urandom), 2);
    repeat (8) @(negedge clk);
    chk(eq_data.size() == 0, "R2", "beats left undelivered",
        128'(eq_data.size()), 128'h0);
    done = 1;
    report();
  end
endmodule